// File: doc/BRIEF.md
# Host-to-Management-Controller Byte Mailbox

This block is a pair of one-byte mailboxes with a shared status byte. It sits between a host-facing register port and a management-controller-facing register port. Each side writes its own outbound byte. Hardware then marks that byte as full and raises a level interrupt toward the other side. The interrupt stays high until the other side reads the byte through its data address, and that read clears the full flag.

Bus decoding, interrupt serialisation and address assignment sit outside this block. Each port offers a one-bit register select: select 0 is the data register and select 1 is the control register. On the host side, a write to the control address is a command byte. It goes into the same inbound register as a data byte, and a status flag records which address was used.

The status byte is shared. The management side owns bits 7, 6, 5, 4 and 2 and writes them through its control address. Hardware owns bit 3 (last host write was a command), bit 1 (inbound full) and bit 0 (outbound full). A status write never raises an interrupt on its own. If a full byte is overwritten before it is consumed, a sticky overrun flag is raised for test.

Top module: `kcs_mailbox`

## Requirements
- R1: After reset both data registers, the status byte, both interrupts and both overrun flags read 0.
- R2: A management write at select 0 stores the byte in the outbound register, sets status bit 0 and raises `host_irq` from the next cycle. A host read at select 0 returns that byte.
- R3: A host write at select 0 stores the byte in the inbound register, sets status bit 1, clears status bit 3 and raises `bmc_irq`. A management read at select 0 returns the byte.
- R4: A host write at select 1 stores the byte in the inbound register, sets status bit 1, sets status bit 3 and raises `bmc_irq`.
- R5: A host read at select 0 clears status bit 0 and `host_irq`. A management read at select 0 clears status bit 1 and `bmc_irq`.
- R6: A management write at select 1 loads bits 7, 6, 5, 4 and 2 of the status byte from the written value. It leaves bits 3, 1 and 0 and both interrupts unchanged.
- R7: A read at select 1 from either side returns the same status byte and changes no state.
- R8: A write to a data register whose full flag is set replaces the byte and keeps the flag set. If no read of that register happens in the same cycle, the matching sticky overrun output is set and stays set until reset.
- R9: A write and a read of the same data register in one cycle leave the flag set and the new byte stored, and raise no overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | Host register select: 0 data, 1 command/status |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data: outbound byte or status |
| host_irq | output | 1 | Level interrupt to host: outbound byte pending |
| bmc_wr | input | 1 | Management write strobe |
| bmc_rd | input | 1 | Management read strobe |
| bmc_sel | input | 1 | Management register select: 0 data, 1 status |
| bmc_wdata | input | DATA_W | Management write data |
| bmc_rdata | output | DATA_W | Management read data: inbound byte or status |
| bmc_irq | output | 1 | Level interrupt to management side: inbound byte pending |
| ovr_inbound | output | 1 | Sticky overrun on the host-to-management register |
| ovr_outbound | output | 1 | Sticky overrun on the management-to-host register |

## Verification
The bench builds the block with the default `DATA_W` of 8, which is the width the status layout is defined for. It covers every status bit position, both ownership groups and the full 256-value byte range. Random strobe traffic on both sides at once reaches the same-cycle write/read collisions and the overruns that directed steps touch only once. A behavioural model of the flags is compared on every clock.

// File: rtl/kcs_mbx_pkg.sv
package kcs_mbx_pkg;

    // Hardware-owned status bit positions; the far side decodes them.
    localparam int OBF_BIT = 0;
    localparam int IBF_BIT = 1;
    localparam int CMD_BIT = 3;

    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;

    // Bits of a status word that software may write.
    function automatic logic [31:0] sw_mask(input int width);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < width && i < 32; i++) begin
            m[i] = !(i == OBF_BIT || i == IBF_BIT || i == CMD_BIT);
        end
        return m;
    endfunction

endpackage

// File: rtl/kcs_mbx_slot.sv
module kcs_mbx_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              ovr_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              ovr;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.data = wdata_i;
            st_d.full = 1'b1;
            if (st_q.full && !rd_i) begin
                st_d.ovr = 1'b1;
            end
        end else if (rd_i) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign full_o = st_q.full;
    assign ovr_o  = st_q.ovr;

    // R2
    wr_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (full_o && data_o == $past(wdata_i)));
    // R5
    rd_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !wr_i) |=> !full_o);
    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |=> ovr_o);
    // R8
    ovr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && full_o && !rd_i) |=> ovr_o);
    // R9
    collide_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && rd_i && !ovr_o) |=> (!ovr_o && full_o));

endmodule

// File: rtl/kcs_mbx_status.sv
module kcs_mbx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr_i,
    input  logic [DATA_W-1:0] sw_wdata_i,
    input  logic              cmd_wr_i,
    input  logic              cmd_val_i,
    input  logic              ibf_i,
    input  logic              obf_i,
    output logic [DATA_W-1:0] status_o
);
    import kcs_mbx_pkg::*;

    localparam logic [DATA_W-1:0] SW_MASK = DATA_W'(sw_mask(DATA_W));

    typedef struct packed {
        logic [DATA_W-1:0] sw;
        logic              cmd;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sw_wr_i) begin
            st_d.sw = sw_wdata_i & SW_MASK;
        end
        if (cmd_wr_i) begin
            st_d.cmd = cmd_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_o          = st_q.sw;
        status_o[CMD_BIT] = st_q.cmd;
        status_o[IBF_BIT] = ibf_i;
        status_o[OBF_BIT] = obf_i;
    end

    // R6
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr_i |=> (status_o[CMD_BIT] == $past(status_o[CMD_BIT])));
    // R6
    sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr_i |=> ((status_o & SW_MASK) == $past(status_o & SW_MASK)));

endmodule

// File: rtl/kcs_mailbox.sv
module kcs_mailbox #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_irq,
    input  logic              bmc_wr,
    input  logic              bmc_rd,
    input  logic              bmc_sel,
    input  logic [DATA_W-1:0] bmc_wdata,
    output logic [DATA_W-1:0] bmc_rdata,
    output logic              bmc_irq,
    output logic              ovr_inbound,
    output logic              ovr_outbound
);
    import kcs_mbx_pkg::*;

    reg_sel_e host_sel_e, bmc_sel_e;
    logic [DATA_W-1:0] in_data, out_data, status;
    logic in_full, out_full;
    logic out_wr, out_rd, in_rd, stat_wr;

    assign host_sel_e = reg_sel_e'(host_sel);
    assign bmc_sel_e  = reg_sel_e'(bmc_sel);

    assign out_wr  = bmc_wr  && bmc_sel_e  == SEL_DATA;
    assign stat_wr = bmc_wr  && bmc_sel_e  == SEL_CTRL;
    assign out_rd  = host_rd && host_sel_e == SEL_DATA;
    assign in_rd   = bmc_rd  && bmc_sel_e  == SEL_DATA;

    kcs_mbx_slot #(.DATA_W(DATA_W)) u_inbound (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (host_wr),
        .wdata_i (host_wdata),
        .rd_i    (in_rd),
        .data_o  (in_data),
        .full_o  (in_full),
        .ovr_o   (ovr_inbound)
    );

    kcs_mbx_slot #(.DATA_W(DATA_W)) u_outbound (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (out_wr),
        .wdata_i (bmc_wdata),
        .rd_i    (out_rd),
        .data_o  (out_data),
        .full_o  (out_full),
        .ovr_o   (ovr_outbound)
    );

    kcs_mbx_status #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_wr_i    (stat_wr),
        .sw_wdata_i (bmc_wdata),
        .cmd_wr_i   (host_wr),
        .cmd_val_i  (host_sel),
        .ibf_i      (in_full),
        .obf_i      (out_full),
        .status_o   (status)
    );

    assign host_rdata = (host_sel_e == SEL_CTRL) ? status : out_data;
    assign bmc_rdata  = (bmc_sel_e  == SEL_CTRL) ? status : in_data;
    assign host_irq   = status[OBF_BIT];
    assign bmc_irq    = status[IBF_BIT];

    // R6
    stat_wr_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !host_wr && !host_rd && !bmc_rd) |=> ($stable(host_irq) && $stable(bmc_irq)));
    // R7
    stat_rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_sel_e == SEL_CTRL && !host_wr && !bmc_wr && !bmc_rd)
        |=> ($stable(status) && $stable(out_data) && $stable(in_data)));
    // R4
    cmd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (bmc_irq && status[CMD_BIT] == $past(host_sel)));

endmodule

// File: tb/sim_kcs_mailbox.sv
module sim_kcs_mailbox;
    localparam int DATA_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 0, host_rd = 0, host_sel = 0;
    logic bmc_wr = 0, bmc_rd = 0, bmc_sel = 0;
    logic [DATA_W-1:0] host_wdata = '0, bmc_wdata = '0;
    logic [DATA_W-1:0] host_rdata, bmc_rdata;
    logic host_irq, bmc_irq, ovr_inbound, ovr_outbound;

    always #10 clk = ~clk;

    kcs_mailbox #(.DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
        .bmc_wr(bmc_wr), .bmc_rd(bmc_rd), .bmc_sel(bmc_sel),
        .bmc_wdata(bmc_wdata), .bmc_rdata(bmc_rdata), .bmc_irq(bmc_irq),
        .ovr_inbound(ovr_inbound), .ovr_outbound(ovr_outbound)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model
    int m_odr, m_idr, m_sw;
    bit m_obf, m_ibf, m_cmd, m_ovi, m_ovo;

    function automatic int m_status();
        return (m_sw & 8'hF4) | (m_cmd << 3) | (m_ibf << 1) | int'(m_obf);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "host_rdata", int'(host_rdata), host_sel ? m_status() : m_odr);
        chk(tag, "bmc_rdata", int'(bmc_rdata), bmc_sel ? m_status() : m_idr);
        chk(tag, "host_irq", int'(host_irq), int'(m_obf));
        chk(tag, "bmc_irq", int'(bmc_irq), int'(m_ibf));
        chk(tag, "ovr_inbound", int'(ovr_inbound), int'(m_ovi));
        chk(tag, "ovr_outbound", int'(ovr_outbound), int'(m_ovo));
    endtask

    task automatic model_step();
        bit hrd_data, brd_data;
        hrd_data = host_rd && !host_sel;
        brd_data = bmc_rd && !bmc_sel;
        if (bmc_wr && !bmc_sel) begin
            if (m_obf && !hrd_data) m_ovo = 1;
            m_odr = int'(bmc_wdata);
            m_obf = 1;
        end else if (hrd_data) m_obf = 0;
        if (bmc_wr && bmc_sel) m_sw = int'(bmc_wdata);
        if (host_wr) begin
            if (m_ibf && !brd_data) m_ovi = 1;
            m_idr = int'(host_wdata);
            m_cmd = host_sel;
            m_ibf = 1;
        end else if (brd_data) m_ibf = 0;
    endtask

    // One cycle: drive at negedge, compare combinational view, advance model.
    task automatic step(string tag, bit hw, bit hr, bit hs, int hd,
                        bit bw, bit br, bit bs, int bd);
        @(negedge clk);
        if (rst_n) compare(tag);
        host_wr = hw; host_rd = hr; host_sel = hs; host_wdata = DATA_W'(hd);
        bmc_wr = bw; bmc_rd = br; bmc_sel = bs; bmc_wdata = DATA_W'(bd);
        #1;
        compare(tag);
        model_step();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_odr = 0; m_idr = 0; m_sw = 0;
        m_obf = 0; m_ibf = 0; m_cmd = 0; m_ovi = 0; m_ovo = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state on both views
        step("R1", 0,0,1,0, 0,0,1,0);
        chk("R1", "status", int'(host_rdata), 0);
        // R2: management data write reaches host
        step("R2", 0,0,0,0, 1,0,0,8'hA5);
        step("R2", 0,0,1,0, 0,0,0,0);
        chk("R2", "obf bit", int'(host_rdata[0]), 1);
        chk("R2", "host_irq", int'(host_irq), 1);
        // R5: host consumes it
        step("R5", 0,1,0,0, 0,0,0,0);
        chk("R5", "byte read", int'(host_rdata), 8'hA5);
        step("R5", 0,0,0,0, 0,0,0,0);
        chk("R5", "host_irq cleared", int'(host_irq), 0);
        // R3: host data write
        step("R3", 1,0,0,8'h3C, 0,0,0,0);
        step("R3", 0,0,0,0, 0,0,1,0);
        chk("R3", "cmd bit", int'(bmc_rdata[3]), 0);
        chk("R3", "ibf bit", int'(bmc_rdata[1]), 1);
        step("R5", 0,0,0,0, 0,1,0,0);
        chk("R3", "inbound byte", int'(bmc_rdata), 8'h3C);
        // R4: host command write
        step("R4", 1,0,1,8'h01, 0,0,0,0);
        step("R4", 0,0,0,0, 0,0,1,0);
        chk("R4", "cmd bit", int'(bmc_rdata[3]), 1);
        chk("R4", "bmc_irq", int'(bmc_irq), 1);
        // R6: status write with all ones
        step("R6", 0,0,0,0, 1,0,1,8'hFF);
        step("R6", 0,0,1,0, 0,0,0,0);
        chk("R6", "status", int'(host_rdata), 8'hF4 | 8'h08 | 8'h02);
        chk("R6", "host_irq", int'(host_irq), 0);
        step("R6", 0,0,0,0, 1,0,1,8'h0B);
        step("R6", 0,0,1,0, 0,0,0,0);
        chk("R6", "hw bits kept", int'(host_rdata), 8'h0A);
        // R7: repeated status reads, both sides
        step("R7", 0,1,1,0, 0,1,1,0);
        step("R7", 0,1,1,0, 0,0,1,0);
        chk("R7", "same status", int'(host_rdata), int'(bmc_rdata));
        chk("R7", "ibf kept", int'(bmc_irq), 1);
        // R8: overwrite inbound while full
        step("R8", 1,0,0,8'h77, 0,0,0,0);
        step("R8", 0,0,0,0, 0,0,0,0);
        chk("R8", "ovr_inbound", int'(ovr_inbound), 1);
        chk("R8", "new byte", int'(bmc_rdata), 8'h77);
        // R9: write and read outbound same cycle
        step("R9", 0,0,0,0, 1,0,0,8'h11);
        step("R9", 0,1,0,0, 1,0,0,8'h22);
        step("R9", 0,0,0,0, 0,0,0,0);
        chk("R9", "ovr_outbound", int'(ovr_outbound), 0);
        chk("R9", "full kept", int'(host_irq), 1);
        chk("R9", "new byte", int'(host_rdata), 8'h22);
        // random traffic on both sides, compared each cycle
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom);
            step("R2", r[0] & r[1], r[2], r[3], int'($urandom_range(0, 255)),
                 r[4] & r[5], r[6], r[7], int'($urandom_range(0, 255)));
        end
        step("R8", 0,0,0,0, 0,0,0,0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule